// File: doc/BRIEF.md
# Sleep-Mode Pad Wakeup Controller

This block models the input path of one low-power pad and a level-triggered external wakeup detector. Three control bits shape the pad's input enable: a normal enable, a sleep-select and a sleep-time enable. When sleep-select is set, the sleep-time enable only takes effect once the chip-sleep status is high. A hold input freezes those control bits so they survive a loss of the register domain. The raw pad signal passes through a two-flop synchronizer and is then gated by the effective enable, so a disabled pad always reads 0.

A sleep request moves the sequencer from `ST_AWAKE` to `ST_ENTRY`, the first sleep cycle. It then moves to `ST_ASLEEP`, where chip-sleep is high. The block counts sleep cycles against a programmable minimum. From the cycle where the count reaches that minimum, it compares the gated pad bit with the programmed wakeup level on every cycle. On a match it moves to `ST_WAKE` for one cycle and then returns to `ST_AWAKE`. The transitions are:
- AWAKE→ENTRY on a sleep request.
- ENTRY→ASLEEP, or ASLEEP→ASLEEP, when there is no match.
- ENTRY→WAKE or ASLEEP→WAKE on a match.
- WAKE→AWAKE always.

The block is used to pick a pad configuration that cannot wake falsely. With sleep-select set, a short minimum count samples the pad while it still reads 0. With the normal enable, the pad reads its true level throughout.

Top module: `padwake_ctrl`

## Requirements
- R1: `pad_ie` equals `ie_sleep & chip_sleep` when the effective `sel_sleep` is 1, and equals `ie_norm` when it is 0.
- R2: `pad_data` is 0 whenever `pad_ie` is 0. Otherwise it equals the synchronized pad level.
- R3: A change on `pad_raw` driven before clock edge k appears on `pad_data` after edge k+1, which is two edges of latency.
- R4: `chip_sleep` is 0 in the sleep entry cycle (count 1). It is 1 from the second sleep cycle (count 2) onward while no wakeup has occurred.
- R5: No wakeup is taken in a sleep cycle whose count is below `min_cycles`. A `min_cycles` of 0 acts as 1.
- R6: In every sleep cycle with count ≥ `min_cycles`, the gated pad bit is compared with `wake_lvl` (0 or 1). A match raises `wake` in the following cycle. A mismatch keeps the block asleep and retries on the next cycle.
- R7: `wake` is high for exactly one cycle, with `chip_sleep` low. The block then rests awake, and a fresh `sleep_req` is required to sleep again. `sleep_req` is ignored while sleeping or waking.
- R8: While `hold` stays high, the control bits take the values they had in the cycle `hold` rose. They ignore later changes. Dropping `hold` returns to the live bits at once.
- R9: With `sel_sleep`=0 and `ie_norm`=1, `pad_ie` is 1 before and after `chip_sleep` rises. A level-0 wakeup never fires while the pad is high.
- R10: Synchronous active-high `rst` returns the block to awake with `chip_sleep` and `wake` low and the counter cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ie_norm | input | 1 | Normal input enable |
| sel_sleep | input | 1 | Sleep-select: use the sleep-time enable |
| ie_sleep | input | 1 | Sleep-time input enable |
| hold | input | 1 | Freeze control bits |
| sleep_req | input | 1 | Request to enter sleep |
| min_cycles | input | CNT_W | Minimum sleep cycles before a wakeup |
| wake_lvl | input | 1 | Pad level that wakes the block |
| pad_raw | input | 1 | Asynchronous external pad level |
| pad_ie | output | 1 | Effective input enable |
| pad_data | output | 1 | Gated, synchronized pad data |
| chip_sleep | output | 1 | Sleep status, high from the second sleep cycle |
| wake | output | 1 | One-cycle wakeup pulse |

## Verification
The hardest situation to reach is the false wakeup. It needs a short minimum count, so that the level comparison falls in the entry cycle where a sleep-selected pad still reads 0. The bench sweeps minimum counts 1 to 4 across both enable configurations, both wakeup levels and both pad levels. It computes, cycle by cycle, the first count at which the gated bit matches the level. This places the count-1 sample, and the false level-0 wake it causes, under direct check. Hold is exercised by changing live bits while frozen and reading `pad_ie` before and after release.

// File: rtl/padwake_pkg.sv
package padwake_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_WAKE   = 2'd3
    } pw_state_e;

    typedef struct packed {
        logic ie;
        logic sel;
        logic slp_ie;
    } pad_ctl_t;
endpackage

// File: rtl/padwake_sync.sv
module padwake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/padwake_hold.sv
module padwake_hold
    import padwake_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  pad_ctl_t live,
    output pad_ctl_t eff
);
    logic     hold_q;
    pad_ctl_t cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            cap    <= '0;
        end else begin
            hold_q <= hold;
            if (hold && !hold_q) cap <= live;
        end
    end

    always_comb begin
        eff = (hold && hold_q) ? cap : live;
    end

    // R8
    held_ctl_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && hold_q && $past(hold && hold_q)) |-> $stable(eff));
endmodule

// File: rtl/padwake_seq.sv
module padwake_seq
    import padwake_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic [CNT_W-1:0] min_cycles,
    input  logic             pad_bit,
    input  logic             wake_lvl,
    output logic             chip_sleep,
    output logic             wake
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    pw_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] min_eff;
    logic             hit;

    assign min_eff = (min_cycles == '0) ? CNT_ONE : min_cycles;
    assign hit     = (cnt >= min_eff) && (pad_bit == wake_lvl);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_AWAKE:  if (sleep_req) state_nx = ST_ENTRY;
            ST_ENTRY:  state_nx = hit ? ST_WAKE : ST_ASLEEP;
            ST_ASLEEP: state_nx = hit ? ST_WAKE : ST_ASLEEP;
            ST_WAKE:   state_nx = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_AWAKE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (state_nx == ST_ENTRY) begin
            cnt <= CNT_ONE;
        end else if (state_nx == ST_ASLEEP) begin
            if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
        end else begin
            cnt <= '0;
        end
    end

    always_comb begin
        chip_sleep = (state == ST_ASLEEP);
        wake       = (state == ST_WAKE);
    end

    // R4
    sleep_rise_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(chip_sleep) |-> (cnt == CNT_W'(2)));
    // R5
    no_early_wake_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wake) |-> ($past(cnt) >= $past(min_eff)));
    // R7
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wake |=> (!wake && !chip_sleep));
    // R7
    sleep_persist_chk: assert property (@(posedge clk) disable iff (rst)
        chip_sleep |=> (chip_sleep || wake));
endmodule

// File: rtl/padwake_ctrl.sv
module padwake_ctrl
    import padwake_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ie_norm,
    input  logic             sel_sleep,
    input  logic             ie_sleep,
    input  logic             hold,
    input  logic             sleep_req,
    input  logic [CNT_W-1:0] min_cycles,
    input  logic             wake_lvl,
    input  logic             pad_raw,
    output logic             pad_ie,
    output logic             pad_data,
    output logic             chip_sleep,
    output logic             wake
);
    pad_ctl_t live_ctl, eff_ctl;
    logic     pad_sync;

    always_comb begin
        live_ctl.ie     = ie_norm;
        live_ctl.sel    = sel_sleep;
        live_ctl.slp_ie = ie_sleep;
    end

    padwake_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .live (live_ctl),
        .eff  (eff_ctl)
    );

    padwake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_raw),
        .q   (pad_sync)
    );

    always_comb begin
        pad_ie   = eff_ctl.sel ? (eff_ctl.slp_ie & chip_sleep) : eff_ctl.ie;
        pad_data = pad_ie & pad_sync;
    end

    padwake_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .min_cycles (min_cycles),
        .pad_bit    (pad_data),
        .wake_lvl   (wake_lvl),
        .chip_sleep (chip_sleep),
        .wake       (wake)
    );

    // R1
    gated_ie_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_sleep && !hold && !chip_sleep) |-> !pad_ie);
    // R9
    normal_ie_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_sleep && ie_norm && !hold) |-> pad_ie);

    generate
        if (SYNC_STAGES == 2) begin : g_lat
            // R3
            sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
                pad_data |-> $past(pad_raw, 2));
        end
    endgenerate
endmodule

// File: tb/padwake_ctrl_bench.sv
module padwake_ctrl_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ie_norm = 1'b0, sel_sleep = 1'b0, ie_sleep = 1'b0, hold = 1'b0;
    logic          sleep_req = 1'b0, wake_lvl = 1'b0, pad_raw = 1'b0;
    logic [CW-1:0] min_cycles = '0;
    logic          pad_ie, pad_data, chip_sleep, wake;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    padwake_ctrl #(.CNT_W(CW)) u_padwake_ctrl (
        .clk(clk), .rst(rst), .ie_norm(ie_norm), .sel_sleep(sel_sleep),
        .ie_sleep(ie_sleep), .hold(hold), .sleep_req(sleep_req),
        .min_cycles(min_cycles), .wake_lvl(wake_lvl), .pad_raw(pad_raw),
        .pad_ie(pad_ie), .pad_data(pad_data), .chip_sleep(chip_sleep), .wake(wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sleep_req = 1'b0; hold = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_cfg(input int cfg);
        ie_norm   = (cfg == 0);
        sel_sleep = (cfg == 1);
        ie_sleep  = (cfg == 1);
    endtask

    task automatic enter_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R10 reset state
        chk("R10 chip_sleep after reset", chip_sleep, 0);
        chk("R10 wake after reset", wake, 0);

        // R3 synchronizer latency, normal enable
        set_cfg(0); pad_raw = 1'b0;
        repeat (3) @(negedge clk);
        pad_raw = 1'b1;
        @(negedge clk);
        chk("R3 pad_data after one edge", pad_data, 0);
        @(negedge clk);
        chk("R3 pad_data after two edges", pad_data, 1);
        pad_raw = 1'b0;
        @(negedge clk);
        chk("R3 pad_data fall one edge", pad_data, 1);
        @(negedge clk);
        chk("R3 pad_data fall two edges", pad_data, 0);

        // R1 R2 R4 R5 R6 R7 R9 sweep
        for (int m = 1; m <= 4; m++) begin
            for (int cfg = 0; cfg < 2; cfg++) begin
                for (int lvl = 0; lvl < 2; lvl++) begin
                    for (int pv = 0; pv < 2; pv++) begin
                        int  expk;
                        bit  woke;
                        string wreq;
                        do_reset();
                        set_cfg(cfg);
                        min_cycles = CW'(m);
                        wake_lvl   = lvl[0];
                        pad_raw    = pv[0];
                        repeat (3) @(negedge clk);
                        expk = 0;
                        for (int k = m + 4; k >= m; k--) begin
                            int v;
                            v = (cfg == 1 && k == 1) ? 0 : pv;
                            if (v == lvl) expk = k;
                        end
                        wreq = (cfg == 0 && lvl == 0 && pv == 1) ? "R9" : "R6";
                        enter_sleep();
                        woke = 1'b0;
                        for (int k = 1; k <= m + 4; k++) begin
                            if (!woke) begin
                                chk("R4 chip_sleep per cycle", chip_sleep, (k >= 2) ? 1 : 0);
                                chk(cfg == 0 ? "R9 pad_ie" : "R1 pad_ie", pad_ie,
                                    cfg == 0 ? 1 : ((k >= 2) ? 1 : 0));
                                chk("R2 pad_data gated", pad_data,
                                    cfg == 0 ? pv : ((k >= 2) ? pv : 0));
                                @(negedge clk);
                                chk(k < m ? "R5 no early wake" : wreq, wake, (k == expk) ? 1 : 0);
                                if (wake) begin
                                    woke = 1'b1;
                                    chk("R7 chip_sleep low with wake", chip_sleep, 0);
                                    sleep_req = 1'b1;
                                    @(negedge clk);
                                    sleep_req = 1'b0;
                                    chk("R7 wake single cycle", wake, 0);
                                    chk("R7 awake after wake", chip_sleep, 0);
                                    @(negedge clk);
                                    chk("R7 sleep_req during wake ignored", chip_sleep, 0);
                                end
                            end
                        end
                    end
                end
            end
        end

        // R5 min_cycles of 0 acts as 1
        do_reset();
        set_cfg(0); min_cycles = '0; wake_lvl = 1'b1; pad_raw = 1'b1;
        repeat (3) @(negedge clk);
        enter_sleep();
        chk("R5 min0 no wake in entry", wake, 0);
        @(negedge clk);
        chk("R5 min0 wakes at count 1", wake, 1);

        // R10 reset during sleep
        do_reset();
        set_cfg(0); min_cycles = CW'(3); wake_lvl = 1'b0; pad_raw = 1'b1;
        repeat (3) @(negedge clk);
        enter_sleep();
        @(negedge clk);
        chk("R10 asleep before reset", chip_sleep, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 chip_sleep cleared", chip_sleep, 0);
        chk("R10 wake cleared", wake, 0);
        pad_raw = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 stays awake without request", chip_sleep + wake, 0);

        // R8 hold freezes control bits
        do_reset();
        set_cfg(1); min_cycles = CW'(8); pad_raw = 1'b1;
        hold = 1'b1;
        @(negedge clk);
        chk("R8 pad_ie at hold capture", pad_ie, 0);
        set_cfg(0);
        #1;
        chk("R8 held ignores live change", pad_ie, 0);
        @(negedge clk);
        chk("R8 held still frozen", pad_ie, 0);
        enter_sleep();
        @(negedge clk);
        chk("R8 frozen sleep path active", pad_ie, 1);
        hold = 1'b0;
        #1;
        chk("R8 release uses live bits", pad_ie, 1);
        set_cfg(2);
        #1;
        chk("R8 live bits after release", pad_ie, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule